// File: doc/BRIEF.md
# Single-Wire Sensor Slave Command Engine

This block is the byte and command layer of a temperature-sensor slave on a single-wire bus. A bit-slot front end, which is not part of this block, reports a detected bus reset, each bit the master writes, and each read slot the master opens. The engine answers every read slot with one bit. After each bus reset it takes a ROM-layer command that selects or identifies the device by its 64-bit identity, and then one function-layer command that works on a nine-byte scratchpad.

The scratchpad holds the last temperature, an upper and a lower alarm threshold, fixed count and filler bytes, and a CRC over the first eight bytes. Temperature samples come in on a 16-bit input with a done strobe. After each sample the engine compares it with the thresholds as signed values and updates an alarm flag. That flag decides whether the device takes part in an alarm-qualified search. The nonvolatile copy of the thresholds is modelled as shadow registers. Copying to them and recalling from them each take a fixed number of cycles.

Top module: `snsw_engine`

## Requirements
- R1: After `rst_n` the engine is idle and the alarm flag is clear. The scratchpad reads as temperature 00AAh (byte 0 = AAh, byte 1 = 00h), thresholds equal to `NV_HI_INIT`/`NV_LO_INIT`, byte 6 = 0Ch, byte 7 = 10h.
- R2: Commands are decoded only in the order bus reset, ROM command, function command. A read slot returns 1 in the idle state, including after power-up with no bus reset and after an unknown ROM command, until the next bus reset.
- R3: Every command and data byte is taken least significant bit first.
- R4: Read ROM (33h) returns the 64-bit identity LSB first. The identity is the family code (parameter, default 10h) in bits 7:0, the 48-bit serial in bits 55:8, and in bits 63:56 the CRC of bits 55:0.
- R5: Match ROM (55h) takes 64 bits. If all of them equal the identity, a function command is accepted next. On the first differing bit the engine ignores all traffic until the next bus reset.
- R6: Skip ROM (CCh) goes straight to function-command decoding.
- R7: Search ROM (F0h) handles each identity bit, from bit 0 upward, in three slots: the engine sends the bit, then its complement, then reads one bit from the master. If the master's bit differs, the engine drops out until the next bus reset. After bit 63 it also waits for a bus reset.
- R8: Alarm search (ECh) acts as R7 when the alarm flag is set. Otherwise it acts as an unknown command, so every read slot returns 1.
- R9: Write scratchpad (4Eh) stores the first byte received as the upper threshold (byte 2) and the second as the lower threshold (byte 3).
- R10: Read scratchpad (BEh) returns 72 bits LSB first, bytes 0 to 8. Bytes 4 and 5 are FFh. Byte 8 is the CRC of bytes 0 to 7 using x^8+x^5+x^4+1, shifted LSB first from a zero start. A bus reset ends a read early, and the next read starts again at bit 0 of byte 0.
- R11: Convert (44h) pulses `conv_start` high for exactly one cycle, in the cycle after the edge that takes the command's last bit. A `conv_done` strobe loads `conv_temp` into bytes 0 and 1.
- R12: On every `conv_done`, the alarm flag is set when `conv_temp[8:1]`, read as a signed byte, is greater than the upper threshold or less than the lower threshold. Otherwise it is cleared. It does not change at any other time.
- R13: Copy (48h) saves bytes 2 and 3 to the shadow registers. Recall (B8h) loads them back. Each takes `NV_DELAY` cycles. While it runs, a read slot returns 0, and after it ends, a read slot returns 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | One-cycle strobe: bus reset seen by the slot layer |
| rx_valid | input | 1 | One-cycle strobe: a master-written bit is on `rx_bit` |
| rx_bit | input | 1 | Received bit value |
| rd_req | input | 1 | One-cycle strobe: the master opened a read slot |
| conv_done | input | 1 | One-cycle strobe: a temperature sample is ready |
| conv_temp | input | 16 | Signed temperature sample, 0.5 degree per LSB |
| tx_bit | output | 1 | Bit for the latest read slot, valid the cycle after `rd_req` |
| conv_start | output | 1 | One-cycle request to start a conversion |

## Verification
The hardest state to reach from the ports is an alarm-qualified search in which the device really does take part. To get there, thresholds must first be written through the function layer, then a conversion result must arrive, and only after a fresh bus reset can the flag be seen, as the first two search slots returning bit 0 and its complement. A table of samples and thresholds walks this whole path for each row. The rows are chosen so that sign handling is the only thing that separates pass from fail (negative thresholds, equal values, -1 against 0). A wrong-bit search, a one-bit mismatch during match and a read cut short by a bus reset are driven as directed sequences.

// File: rtl/snsw_pkg.sv
package snsw_pkg;
  localparam logic [7:0] ROM_SEARCH = 8'hF0;
  localparam logic [7:0] ROM_READ   = 8'h33;
  localparam logic [7:0] ROM_MATCH  = 8'h55;
  localparam logic [7:0] ROM_SKIP   = 8'hCC;
  localparam logic [7:0] ROM_ALARM  = 8'hEC;
  localparam logic [7:0] FN_CONVERT = 8'h44;
  localparam logic [7:0] FN_WRITE   = 8'h4E;
  localparam logic [7:0] FN_READ    = 8'hBE;
  localparam logic [7:0] FN_COPY    = 8'h48;
  localparam logic [7:0] FN_RECALL  = 8'hB8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ROMCMD, ST_MATCH, ST_SEARCH, ST_ROMTX,
    ST_FNCMD, ST_WRSP, ST_RDSP, ST_NVOP
  } eng_state_t;

  // CRC x^8+x^5+x^4+1, data shifted in LSB first, zero start
  function automatic logic [7:0] crc8_lsb(input logic [63:0] data, input int nbits);
    logic [7:0] c;
    logic       fb;
    c = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < nbits) begin
        fb = c[0] ^ data[i];
        c  = {1'b0, c[7:1]} ^ (fb ? 8'h8C : 8'h00);
      end
    end
    return c;
  endfunction
endpackage

// File: rtl/snsw_rx_byte.sv
module snsw_rx_byte #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          rx_valid,
  input  logic          rx_bit,
  output logic          byte_done,
  output logic [BW-1:0] byte_val
);
  localparam int CW = $clog2(BW);

  logic [BW-2:0] sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (rx_valid) begin
      sh_d  = {rx_bit, sh_q[BW-2:1]};
      cnt_d = (cnt_q == CW'(BW-1)) ? '0 : cnt_q + 1'b1;
    end
  end

  assign byte_done = rx_valid && !clr && (cnt_q == CW'(BW-1));
  assign byte_val  = {rx_bit, sh_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/snsw_scratchpad.sv
module snsw_scratchpad
  import snsw_pkg::*;
#(
  parameter logic [7:0] NV_HI_INIT = 8'h4B,
  parameter logic [7:0] NV_LO_INIT = 8'h46,
  parameter int          NV_DELAY  = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hi,
  input  logic        wr_lo,
  input  logic [7:0]  wdata,
  input  logic        conv_done,
  input  logic [15:0] conv_temp,
  input  logic        copy_go,
  input  logic        recall_go,
  output logic [71:0] image,
  output logic        alarm,
  output logic        nv_busy
);
  localparam int CW = $clog2(NV_DELAY + 1);

  logic [15:0]   temp_q, temp_d;
  logic [7:0]    th_q, th_d, tl_q, tl_d, nvh_q, nvh_d, nvl_q, nvl_d;
  logic          al_q, al_d, busy_q, busy_d, op_q, op_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [63:0]   body;
  logic signed [7:0] t_cmp;

  assign t_cmp = $signed(conv_temp[8:1]);

  always_comb begin
    temp_d = temp_q; th_d = th_q; tl_d = tl_q; nvh_d = nvh_q; nvl_d = nvl_q;
    al_d = al_q; busy_d = busy_q; op_d = op_q; cnt_d = cnt_q;
    if (conv_done) begin
      temp_d = conv_temp;
      al_d   = (t_cmp > $signed(th_q)) || (t_cmp < $signed(tl_q));
    end
    if (wr_hi) th_d = wdata;
    if (wr_lo) tl_d = wdata;
    if (busy_q) begin
      if (cnt_q == CW'(NV_DELAY - 1)) begin
        busy_d = 1'b0;
        cnt_d  = '0;
        if (op_q) begin
          th_d = nvh_q;
          tl_d = nvl_q;
        end else begin
          nvh_d = th_q;
          nvl_d = tl_q;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (copy_go || recall_go) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      op_d   = recall_go;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_q <= 16'h00AA;
      th_q   <= NV_HI_INIT;
      tl_q   <= NV_LO_INIT;
      nvh_q  <= NV_HI_INIT;
      nvl_q  <= NV_LO_INIT;
      al_q   <= 1'b0;
      busy_q <= 1'b0;
      op_q   <= 1'b0;
      cnt_q  <= '0;
    end else begin
      temp_q <= temp_d;
      th_q   <= th_d;
      tl_q   <= tl_d;
      nvh_q  <= nvh_d;
      nvl_q  <= nvl_d;
      al_q   <= al_d;
      busy_q <= busy_d;
      op_q   <= op_d;
      cnt_q  <= cnt_d;
    end
  end

  assign body    = {8'h10, 8'h0C, 8'hFF, 8'hFF, tl_q, th_q, temp_q};
  assign image   = {crc8_lsb(body, 64), body};
  assign alarm   = al_q;
  assign nv_busy = busy_q;

  a_r11_temp_only_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(temp_q));
  a_r12_alarm_only_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(al_q));
  a_r9_upper_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hi && !busy_q) |=> $stable(th_q));
endmodule

// File: rtl/snsw_engine.sv
module snsw_engine
  import snsw_pkg::*;
#(
  parameter logic [7:0]  FAMILY     = 8'h10,
  parameter logic [47:0] SERIAL     = 48'hA5C3_0F1E_2D3C,
  parameter logic [7:0]  NV_HI_INIT = 8'h4B,
  parameter logic [7:0]  NV_LO_INIT = 8'h46,
  parameter int          NV_DELAY   = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_reset,
  input  logic        rx_valid,
  input  logic        rx_bit,
  input  logic        rd_req,
  input  logic        conv_done,
  input  logic [15:0] conv_temp,
  output logic        tx_bit,
  output logic        conv_start
);
  localparam logic [55:0] ID_LOW = {SERIAL, FAMILY};
  localparam logic [63:0] ID     = {crc8_lsb({8'h00, ID_LOW}, 56), ID_LOW};
  localparam int          IW     = 7;

  eng_state_t    st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [1:0]    ph_q, ph_d;
  logic          tx_q, tx_d, cs_q, cs_d, ws_q, ws_d;
  logic          byte_done, wr_hi, wr_lo, copy_go, recall_go, alarm, nv_busy;
  logic [7:0]    byte_val;
  logic [71:0]   image;
  logic          id_bit;

  snsw_rx_byte #(.BW(8)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(bus_reset), .rx_valid(rx_valid),
    .rx_bit(rx_bit), .byte_done(byte_done), .byte_val(byte_val)
  );

  snsw_scratchpad #(.NV_HI_INIT(NV_HI_INIT), .NV_LO_INIT(NV_LO_INIT),
                    .NV_DELAY(NV_DELAY)) u_sp (
    .clk(clk), .rst_n(rst_n), .wr_hi(wr_hi), .wr_lo(wr_lo), .wdata(byte_val),
    .conv_done(conv_done), .conv_temp(conv_temp), .copy_go(copy_go),
    .recall_go(recall_go), .image(image), .alarm(alarm), .nv_busy(nv_busy)
  );

  assign id_bit = ID[idx_q[5:0]];

  always_comb begin
    st_d = st_q; idx_d = idx_q; ph_d = ph_q; tx_d = tx_q; ws_d = ws_q;
    cs_d = 1'b0; wr_hi = 1'b0; wr_lo = 1'b0; copy_go = 1'b0; recall_go = 1'b0;
    if (bus_reset) begin
      st_d = ST_ROMCMD; idx_d = '0; ph_d = '0; tx_d = 1'b1;
    end else begin
      if (rd_req) tx_d = 1'b1;
      case (st_q)
        ST_ROMCMD: if (byte_done) begin
          idx_d = '0; ph_d = '0;
          case (byte_val)
            ROM_SEARCH: st_d = ST_SEARCH;
            ROM_ALARM:  st_d = alarm ? ST_SEARCH : ST_IDLE;
            ROM_READ:   st_d = ST_ROMTX;
            ROM_MATCH:  st_d = ST_MATCH;
            ROM_SKIP:   st_d = ST_FNCMD;
            default:    st_d = ST_IDLE;
          endcase
        end
        ST_MATCH: if (rx_valid) begin
          if (rx_bit != id_bit)            st_d = ST_IDLE;
          else if (idx_q == IW'(63))       st_d = ST_FNCMD;
          else                             idx_d = idx_q + 1'b1;
        end
        ST_SEARCH: begin
          if (ph_q == 2'd0 && rd_req) begin
            tx_d = id_bit; ph_d = 2'd1;
          end else if (ph_q == 2'd1 && rd_req) begin
            tx_d = ~id_bit; ph_d = 2'd2;
          end else if (ph_q == 2'd2 && rx_valid) begin
            if (rx_bit != id_bit || idx_q == IW'(63)) st_d = ST_IDLE;
            else begin
              idx_d = idx_q + 1'b1; ph_d = 2'd0;
            end
          end
        end
        ST_ROMTX: if (rd_req) begin
          tx_d = id_bit;
          if (idx_q == IW'(63)) st_d = ST_FNCMD;
          else                  idx_d = idx_q + 1'b1;
        end
        ST_FNCMD: if (byte_done) begin
          idx_d = '0;
          case (byte_val)
            FN_CONVERT: begin cs_d = 1'b1; st_d = ST_IDLE; end
            FN_WRITE:   begin ws_d = 1'b0; st_d = ST_WRSP; end
            FN_READ:    st_d = ST_RDSP;
            FN_COPY:    begin copy_go = 1'b1; st_d = ST_NVOP; end
            FN_RECALL:  begin recall_go = 1'b1; st_d = ST_NVOP; end
            default:    st_d = ST_IDLE;
          endcase
        end
        ST_WRSP: if (byte_done) begin
          if (!ws_q) begin wr_hi = 1'b1; ws_d = 1'b1; end
          else       begin wr_lo = 1'b1; st_d = ST_IDLE; end
        end
        ST_RDSP: if (rd_req) begin
          tx_d = image[idx_q];
          if (idx_q == IW'(71)) st_d = ST_IDLE;
          else                  idx_d = idx_q + 1'b1;
        end
        ST_NVOP: if (rd_req) tx_d = ~nv_busy;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      ph_q  <= '0;
      tx_q  <= 1'b1;
      cs_q  <= 1'b0;
      ws_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      ph_q  <= ph_d;
      tx_q  <= tx_d;
      cs_q  <= cs_d;
      ws_q  <= ws_d;
    end
  end

  assign tx_bit     = tx_q;
  assign conv_start = cs_q;

  a_r2_idle_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && rd_req && !bus_reset) |=> tx_bit);
  a_r2_reset_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (st_q == ST_ROMCMD));
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  a_r7_drop_on_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEARCH && ph_q == 2'd2 && rx_valid && !bus_reset && rx_bit != id_bit)
      |=> (st_q == ST_IDLE));
endmodule

// File: tb/snsw_engine_tb.sv
module snsw_engine_tb;
  localparam logic [7:0]  FAM = 8'h10;
  localparam logic [47:0] SER = 48'hA5C3_0F1E_2D3C;
  localparam logic [7:0]  NVH = 8'h4B;
  localparam logic [7:0]  NVL = 8'h46;
  localparam int          DLY = 20;

  // {temp, upper, lower, expected alarm}
  localparam logic [32:0] VEC [8] = '{
    {16'h0032, 8'h1E, 8'h0A, 1'b0},
    {16'h0032, 8'h14, 8'h0A, 1'b1},
    {16'hFF92, 8'h1E, 8'hF6, 1'b1},
    {16'hFFCE, 8'h00, 8'hE2, 1'b0},
    {16'h0032, 8'h19, 8'h19, 1'b0},
    {16'h00AA, 8'h80, 8'h7F, 1'b1},
    {16'hFFFF, 8'hFF, 8'hFF, 1'b0},
    {16'h0001, 8'hFF, 8'h80, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, bus_reset = 1'b0, rx_valid = 1'b0, rx_bit = 1'b0;
  logic rd_req = 1'b0, conv_done = 1'b0;
  logic [15:0] conv_temp = '0;
  logic tx_bit, conv_start;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  snsw_engine #(.FAMILY(FAM), .SERIAL(SER), .NV_HI_INIT(NVH), .NV_LO_INIT(NVL),
                .NV_DELAY(DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid),
    .rx_bit(rx_bit), .rd_req(rd_req), .conv_done(conv_done),
    .conv_temp(conv_temp), .tx_bit(tx_bit), .conv_start(conv_start)
  );

  function automatic logic [7:0] ref_crc(input logic [63:0] d, input int n);
    logic [7:0] c;
    logic fb;
    c = '0;
    for (int i = 0; i < n; i++) begin
      fb = c[0] ^ d[i];
      c = {1'b0, c[7:1]};
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  function automatic logic [63:0] ref_id();
    logic [55:0] lo;
    lo = {SER, FAM};
    return {ref_crc({8'h00, lo}, 56), lo};
  endfunction

  function automatic logic [71:0] ref_sp(input logic [15:0] t, input logic [7:0] hi, lo);
    logic [63:0] b;
    b = {8'h10, 8'h0C, 8'hFF, 8'hFF, lo, hi, t};
    return {ref_crc(b, 64), b};
  endfunction

  task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); rx_valid = 1'b1; rx_bit = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic read_bit(output logic b);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0; b = tx_bit;
  endtask

  task automatic read_bits(input int n, output logic [71:0] v);
    logic b;
    v = '0;
    for (int i = 0; i < n; i++) begin
      read_bit(b);
      v[i] = b;
    end
  endtask

  task automatic pulse_reset();
    @(negedge clk); bus_reset = 1'b1;
    @(negedge clk); bus_reset = 1'b0;
  endtask

  task automatic write_sp(input logic [7:0] hi, input logic [7:0] lo);
    pulse_reset(); send_byte(8'hCC); send_byte(8'h4E); send_byte(hi); send_byte(lo);
  endtask

  task automatic read_sp(output logic [71:0] v);
    pulse_reset(); send_byte(8'hCC); send_byte(8'hBE); read_bits(72, v);
  endtask

  task automatic sample(input logic [15:0] t);
    @(negedge clk); conv_done = 1'b1; conv_temp = t;
    @(negedge clk); conv_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R2 watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [71:0] v;
    logic [63:0] id, gb, gn;
    logic b, nb;
    id = ref_id();
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R2: no bus reset yet, command bytes ignored, reads give 1
    send_byte(8'hBE); read_bits(8, v);
    check("R2 idle before bus reset", v, 72'hFF);

    // R1 R6 R10: power-up scratchpad image through skip + read
    read_sp(v);
    check("R1 R6 R10 power-up scratchpad", v, ref_sp(16'h00AA, NVH, NVL));

    // R1 R8: alarm clear after reset, alarm search stays silent
    pulse_reset(); send_byte(8'hEC); read_bits(2, v);
    check("R1 R8 no alarm after reset", v, 72'h3);

    // R4: read ROM
    pulse_reset(); send_byte(8'h33); read_bits(64, v);
    check("R4 identity", v, {8'h00, id});
    check("R4 family byte", {64'h0, v[7:0]}, {64'h0, FAM});

    // R5: match with full identity, then function command works
    pulse_reset(); send_byte(8'h55);
    for (int i = 0; i < 64; i++) send_bit(id[i]);
    send_byte(8'hBE); read_bits(16, v);
    check("R5 match accepted", v, 72'h00AA);

    // R5: one differing bit, rest ignored
    pulse_reset(); send_byte(8'h55);
    for (int i = 0; i < 64; i++) send_bit(i == 40 ? ~id[i] : id[i]);
    send_byte(8'hBE); read_bits(16, v);
    check("R5 mismatch ignored", v, 72'hFFFF);

    // R2: unknown ROM command
    pulse_reset(); send_byte(8'h44); send_byte(8'hBE); read_bits(8, v);
    check("R2 unknown rom command", v, 72'hFF);

    // R7: full search
    pulse_reset(); send_byte(8'hF0);
    gb = '0; gn = '0;
    for (int i = 0; i < 64; i++) begin
      read_bit(b); read_bit(nb);
      gb[i] = b; gn[i] = nb;
      send_bit(id[i]);
    end
    check("R7 search bits", {8'h0, gb}, {8'h0, id});
    check("R7 search complements", {8'h0, gn}, {8'h0, ~id});
    read_bit(b);
    check("R7 after search", {71'h0, b}, 72'h1);

    // R7: master picks the other branch, slave drops out
    pulse_reset(); send_byte(8'hF0); read_bits(2, v); send_bit(~id[0]);
    read_bits(2, v);
    check("R7 dropped out", v, 72'h3);

    // R3 R8 R9 R10 R11 R12: sample/threshold table
    for (int k = 0; k < 8; k++) begin
      write_sp(VEC[k][16:9], VEC[k][8:1]);
      sample(VEC[k][32:17]);
      pulse_reset(); send_byte(8'hEC); read_bits(2, v);
      check($sformatf("R12 R8 alarm row %0d", k), v,
            VEC[k][0] ? 72'h2 : 72'h3);
      read_sp(v);
      check($sformatf("R3 R9 R10 R11 image row %0d", k), v,
            ref_sp(VEC[k][32:17], VEC[k][16:9], VEC[k][8:1]));
    end

    // R11: convert command pulse
    pulse_reset(); send_byte(8'hCC); send_byte(8'h44);
    check("R11 conv_start high", {71'h0, conv_start}, 72'h1);
    tick();
    check("R11 conv_start one cycle", {71'h0, conv_start}, 72'h0);

    // R10: aborted read then full read
    pulse_reset(); send_byte(8'hCC); send_byte(8'hBE); read_bits(8, v);
    read_sp(v);
    check("R10 read after abort", v, ref_sp(16'h0001, 8'hFF, 8'h80));

    // R13: copy then recall
    write_sp(8'h11, 8'h22);
    pulse_reset(); send_byte(8'hCC); send_byte(8'h48);
    read_bit(b);
    check("R13 copy busy", {71'h0, b}, 72'h0);
    repeat (DLY + 4) tick();
    read_bit(b);
    check("R13 copy done", {71'h0, b}, 72'h1);
    write_sp(8'h33, 8'h44);
    pulse_reset(); send_byte(8'hCC); send_byte(8'hB8);
    read_bit(b);
    check("R13 recall busy", {71'h0, b}, 72'h0);
    repeat (DLY + 4) tick();
    read_bit(b);
    check("R13 recall done", {71'h0, b}, 72'h1);
    read_sp(v);
    check("R13 recalled thresholds", {56'h0, v[31:16]}, 72'h2211);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule